// File: doc/BRIEF.md
# FIFO Word Sample Unpacker

This block sits between an upstream audio FIFO and a serial audio transmitter. It takes one 64-bit word at a time and cuts it into audio samples. Samples are packed into the word starting at the least significant end. A three-bit packing code selects the slot layout: eight 8-bit slots, four 16-bit slots or two 32-bit slots. A five-bit field gives the index of the real MSB inside each slot, so right-justified 20-bit or 24-bit samples in wider slots are found and realigned at run time.

Each emitted sample is 24 bits wide with its MSB at bit 23, and each carries a left/right tag. A channel mask picks mono or stereo consumption. In stereo, consecutive slots alternate between left and right. In mono, every slot is sent to both sides. Both the input side and the output side use valid/ready handshakes. A fresh word is taken only once every emission of the held word has been accepted.

Top module: `fifo_sample_unpacker`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Packing code 0 gives eight 8-bit slots. Slot k occupies in_data bits [8k+7:8k], and slots are emitted from k=0 upward.
- R3: Packing code 2 gives four 16-bit slots. Slot k occupies in_data bits [16k+15:16k], and slots are emitted in ascending order.
- R4: Packing code 4, and every other code (1, 3, 5, 6, 7), gives two 32-bit slots: bits [31:0] first, then bits [63:32].
- R5: The effective MSB index is the smaller of cfg_msb_pos and the slot width minus 1. Slot bits from that index down to bit 0 are placed so that the MSB lands on out_sample bit 23. Output bits below the field are 0, and field bits that fall below bit 0 are dropped.
- R6: Stereo mode applies when any cfg_chan_mask bit above bit 0 is set (for example 0x3). Each slot is emitted once. Even slots have out_right=0 and odd slots have out_right=1.
- R7: Mono mode applies when cfg_chan_mask bits [7:1] are all 0 (for example 0x1). Each slot is emitted twice, first with out_right=0 and then with out_right=1, with the same out_sample value both times.
- R8: in_ready is 1 only when no word is held, or in the cycle where the held word's last emission is being accepted. While out_valid is 1 and out_ready is 0, in_ready is 0.
- R9: While out_valid is 1 and out_ready is 0, out_sample and out_right stay unchanged in the next cycle.
- R10: A word accepted at a clock edge has its first sample, tagged left, on the outputs with out_valid=1 directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pack | input | 3 | Packing code (0: 8-bit, 2: 16-bit, others: 32-bit slots) |
| cfg_msb_pos | input | 5 | Index of the sample MSB inside its slot |
| cfg_chan_mask | input | 8 | Channel mask; 0x1 selects mono, 0x3 selects stereo |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | 64 | Packed upstream word |
| in_ready | output | 1 | Block can take a word this cycle |
| out_valid | output | 1 | A sample is presented |
| out_sample | output | 24 | Sample, MSB at bit 23 |
| out_right | output | 1 | 0: left channel, 1: right channel |
| out_ready | input | 1 | Transmitter accepts the sample |

## Verification
A word accepted at an edge yields its first sample with no further register delay, so it is visible in the cycle that follows. Each later sample appears in the cycle after the preceding one is taken. The bench drives its inputs on the falling edge and samples one nanosecond later, which is still before the rising edge. It compares every taken sample, in order, against a queue filled at the moment of acceptance. This ordering makes the check independent of how many stall cycles occur. A separate check requires out_valid with a left tag exactly one cycle after each acceptance. Another checks that in_ready stays low in every stalled cycle.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned SLOT_MAX = 32;

  typedef enum logic [2:0] {
    PK_BYTE = 3'd0,
    PK_HALF = 3'd2,
    PK_WORD = 3'd4
  } pack_e;

  // Number of slots in a word, minus one, for a packing code.
  function automatic logic [2:0] pk_last_slot(input logic [2:0] code);
    case (code)
      PK_BYTE: return 3'd7;
      PK_HALF: return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  // Largest MSB index a slot can hold.
  function automatic logic [4:0] pk_slot_top(input logic [2:0] code);
    case (code)
      PK_BYTE: return 5'd7;
      PK_HALF: return 5'd15;
      default: return 5'd31;
    endcase
  endfunction

  function automatic logic [4:0] pk_eff_msb(input logic [2:0] code, input logic [4:0] msb);
    logic [4:0] top;
    top = pk_slot_top(code);
    return (msb > top) ? top : msb;
  endfunction

  // Keep bits eff..0 of the slot, then move bit eff onto bit 23.
  function automatic logic [SAMPLE_W-1:0] pk_align(input logic [SLOT_MAX-1:0] field,
                                                   input logic [4:0] eff);
    logic [SLOT_MAX-1:0] keep;
    logic [SLOT_MAX-1:0] moved;
    keep = field & ((32'd2 << eff) - 32'd1);
    if (eff >= 5'd23) moved = keep >> (eff - 5'd23);
    else              moved = keep << (5'd23 - eff);
    return moved[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/unpk_slot_pick.sv
module unpk_slot_pick
  import unpk_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0]   word,
  input  logic [2:0]          code,
  input  logic [2:0]          slot,
  output logic [SLOT_MAX-1:0] field
);
  localparam int unsigned N8  = WORD_W / 8;
  localparam int unsigned N16 = WORD_W / 16;
  localparam int unsigned N32 = WORD_W / 32;

  logic [7:0]  s8  [N8];
  logic [15:0] s16 [N16];
  logic [31:0] s32 [N32];

  for (genvar g = 0; g < N8; g++) begin : g_b
    assign s8[g] = word[g*8 +: 8];
  end
  for (genvar g = 0; g < N16; g++) begin : g_h
    assign s16[g] = word[g*16 +: 16];
  end
  for (genvar g = 0; g < N32; g++) begin : g_w
    assign s32[g] = word[g*32 +: 32];
  end

  always_comb begin
    case (code)
      PK_BYTE: field = {24'd0, s8[slot]};
      PK_HALF: field = {16'd0, s16[slot[1:0]]};
      default: field = s32[slot[0]];
    endcase
  end
endmodule

// File: rtl/unpk_msb_align.sv
module unpk_msb_align
  import unpk_pkg::*;
(
  input  logic [SLOT_MAX-1:0] field,
  input  logic [2:0]          code,
  input  logic [4:0]          msb_pos,
  output logic [SAMPLE_W-1:0] sample
);
  logic [4:0] eff_msb;
  assign eff_msb = pk_eff_msb(code, msb_pos);
  assign sample  = pk_align(field, eff_msb);
endmodule

// File: rtl/unpk_seq.sv
module unpk_seq
  import unpk_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        code,
  input  logic              stereo,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_right,
  input  logic              out_ready,
  output logic [WORD_W-1:0] word_q,
  output logic [2:0]        slot_q
);
  logic held_q, dup_q;
  logic emit_fire, last_emit, word_take;

  assign emit_fire = held_q && out_ready;
  assign last_emit = (slot_q == pk_last_slot(code)) && (stereo || dup_q);
  assign in_ready  = !held_q || (emit_fire && last_emit);
  assign word_take = in_valid && in_ready;
  assign out_valid = held_q;
  assign out_right = stereo ? slot_q[0] : dup_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      slot_q <= '0;
      dup_q  <= 1'b0;
      word_q <= '0;
    end else if (word_take) begin
      held_q <= 1'b1;
      slot_q <= '0;
      dup_q  <= 1'b0;
      word_q <= in_data;
    end else if (emit_fire) begin
      if (last_emit) begin
        held_q <= 1'b0;
      end else if (!stereo && !dup_q) begin
        dup_q <= 1'b1;
      end else begin
        dup_q  <= 1'b0;
        slot_q <= slot_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/fifo_sample_unpacker.sv
module fifo_sample_unpacker
  import unpk_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned OUT_W  = SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_pack,
  input  logic [4:0]        cfg_msb_pos,
  input  logic [7:0]        cfg_chan_mask,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_sample,
  output logic              out_right,
  input  logic              out_ready
);
  logic                stereo;
  logic [WORD_W-1:0]   word_q;
  logic [2:0]          slot_q;
  logic [SLOT_MAX-1:0] field;
  logic [SAMPLE_W-1:0] aligned;

  assign stereo = (cfg_chan_mask & 8'hFE) != 8'h00;

  unpk_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .code(cfg_pack), .stereo(stereo),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_right(out_right), .out_ready(out_ready),
    .word_q(word_q), .slot_q(slot_q)
  );

  unpk_slot_pick #(.WORD_W(WORD_W)) u_pick (
    .word(word_q), .code(cfg_pack), .slot(slot_q), .field(field)
  );

  unpk_msb_align u_align (
    .field(field), .code(cfg_pack), .msb_pos(cfg_msb_pos), .sample(aligned)
  );

  assign out_sample = aligned[OUT_W-1:0];
endmodule

// File: rtl/unpk_checker.sv
module unpk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  cfg_msb_pos,
  input logic [7:0]  cfg_chan_mask,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic [23:0] out_sample,
  input logic        out_right,
  input logic        out_ready
);
  logic take_out, take_in, mono;
  assign take_out = out_valid && out_ready;
  assign take_in  = in_valid && in_ready;
  assign mono     = (cfg_chan_mask & 8'hFE) == 8'h00;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_right)));

  // R8
  no_early_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  accept_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_in |=> (out_valid && !out_right));

  // R6
  side_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_out |=> (!out_valid || (out_right != $past(out_right))));

  // R7
  mono_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_out && !out_right && mono) |=> (out_valid && out_right && out_sample == $past(out_sample)));

  // R5
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_msb_pos < 5'd23) |->
      ((out_sample & ((24'd1 << (5'd23 - cfg_msb_pos)) - 24'd1)) == 24'd0));
endmodule

bind fifo_sample_unpacker unpk_checker u_unpk_chk (
  .clk(clk), .rst_n(rst_n), .cfg_msb_pos(cfg_msb_pos), .cfg_chan_mask(cfg_chan_mask),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_sample(out_sample), .out_right(out_right), .out_ready(out_ready)
);

// File: tb/fifo_sample_unpacker_bench.sv
module fifo_sample_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_pack = 3'd0;
  logic [4:0]  cfg_msb_pos = 5'd7;
  logic [7:0]  cfg_chan_mask = 8'h1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready, out_valid, out_right;
  logic [23:0] out_sample;
  logic        out_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [24:0] exp_q[$];
  logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

  always #2 clk = ~clk;

  fifo_sample_unpacker u_fifo_sample_unpacker (
    .clk(clk), .rst_n(rst_n), .cfg_pack(cfg_pack), .cfg_msb_pos(cfg_msb_pos),
    .cfg_chan_mask(cfg_chan_mask), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample),
    .out_right(out_right), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] next_word(input logic [63:0] s);
    logic [63:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // Bit-by-bit reference: output bit k takes slot bit eff-(23-k).
  function automatic logic [23:0] ref_sample(input logic [63:0] w, input int sw, input int s, input int msb);
    logic [23:0] r;
    int eff;
    eff = (msb > sw - 1) ? sw - 1 : msb;
    r = '0;
    for (int k = 0; k < 24; k++) begin
      int idx;
      idx = eff - (23 - k);
      if (idx >= 0) r[k] = w[s*sw + idx];
    end
    return r;
  endfunction

  task automatic push_word(input logic [63:0] w);
    int sw;
    sw = (cfg_pack == 3'd0) ? 8 : (cfg_pack == 3'd2) ? 16 : 32;
    for (int s = 0; s < 64 / sw; s++) begin
      logic [23:0] v;
      v = ref_sample(w, sw, s, int'(cfg_msb_pos));
      if (cfg_chan_mask[7:1] != 7'd0) exp_q.push_back({s[0], v});
      else begin
        exp_q.push_back({1'b0, v});
        exp_q.push_back({1'b1, v});
      end
    end
  endtask

  task automatic run_cfg(input logic [2:0] pk, input logic [4:0] msb, input logic [7:0] mask);
    int sent;
    bit expect_new;
    string tag;
    cfg_pack = pk; cfg_msb_pos = msb; cfg_chan_mask = mask;
    tag = $sformatf("%s/R5/%s pk=%0d msb=%0d",
                    (pk == 3'd0) ? "R2" : (pk == 3'd2) ? "R3" : "R4",
                    (mask[7:1] != 0) ? "R6" : "R7", pk, msb);
    sent = 0;
    expect_new = 1'b0;
    while (sent < 2 || exp_q.size() > 0 || out_valid) begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 5) != 3;
      in_valid = (sent < 2);
      in_data = seed;
      #1;
      if (expect_new) begin
        // R10
        chk(out_valid && !out_right, "R10 first sample after accept", {out_valid, out_right}, 2'b10);
        expect_new = 1'b0;
      end
      if (out_valid && !out_ready)
        chk(!in_ready, "R8 in_ready during stall", in_ready, 1'b0);
      if (out_valid && out_ready) begin
        logic [24:0] e;
        if (exp_q.size() == 0) begin
          chk(1'b0, {"R8 extra sample ", tag}, {out_right, out_sample}, 0);
        end else begin
          e = exp_q.pop_front();
          chk({out_right, out_sample} == e, tag, {out_right, out_sample}, e);
        end
      end
      if (in_valid && in_ready) begin
        if (out_valid && exp_q.size() != 0)
          chk(1'b0, "R8 accept before word drained", exp_q.size(), 0);
        push_word(seed);
        seed = next_word(seed);
        sent++;
        expect_new = 1'b1;
      end
      if (cyc > 150000) break;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] pks [5];
    logic [4:0] msbs [6];
    pks = '{3'd0, 3'd2, 3'd4, 3'd1, 3'd7};
    msbs = '{5'd7, 5'd15, 5'd19, 5'd23, 5'd27, 5'd31};
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(!out_valid, "R1 out_valid after reset", out_valid, 1'b0);
    chk(in_ready, "R1 in_ready after reset", in_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R1 idle after release", {out_valid, in_ready}, 2'b01);
    for (int p = 0; p < 5; p++)
      for (int m = 0; m < 6; m++) begin
        run_cfg(pks[p], msbs[m], 8'h03);
        run_cfg(pks[p], msbs[m], 8'h01);
      end
    // R6: another mask with a high bit set behaves as stereo
    run_cfg(3'd2, 5'd15, 8'h82);
    chk(exp_q.size() == 0, "R8 all samples drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule